// File: doc/BRIEF.md
# Burst SRAM Access Sequencer

This block is the control and address engine in front of a synchronous, common-I/O static RAM that supports bursts of up to four beats. On each rising clock edge where the stall input is low, it decodes the chip select, the load/advance control and the write enable into one of three cycle types. A load with chip select starts a burst. A load without chip select deselects the device. An advance steps the current burst forward. When the stall input is high, the edge is a wait cycle and nothing moves.

The block supplies the memory address for the current beat. The upper bits are held from the loaded address. The two low bits follow either linear or interleaved order from the loaded offset. It also supplies read and write strobes and the byte enables for the current beat. It produces the drive enable for the shared data bus: output enable is combined asynchronously with the read state, so the bus is never driven during a write. An asynchronous sleep request passes through a synchronizer. While the device is asleep, and for a short recovery window after it wakes, access attempts are refused and flagged.

Top module: `burst_seq`

## Requirements
- R1: On an edge with `hold`=0, `advance`=0 and `chip_sel`=1, a burst begins at `addr_in`. After that edge, `mem_addr` equals `addr_in`, and `mem_wr` is 1 if `wr` was 1 or `mem_rd` is 1 if `wr` was 0.
- R2: On an edge with `hold`=0 and `advance`=1 during a burst, the beat count steps by one. The read/write type is kept from the first beat, and `chip_sel` and `wr` have no effect.
- R3: The two low address bits equal the loaded offset plus the beat count modulo 4 when `burst_order`=0, and the loaded offset XOR the beat count when `burst_order`=1. The bits above bit 1 never change within a burst. After the fourth beat the sequence wraps back to the starting offset.
- R4: On an edge with `hold`=0, `advance`=0 and `chip_sel`=0, the device is deselected and both strobes go to 0. An advance while deselected keeps it deselected, even with `chip_sel`=1.
- R5: On an edge with `hold`=1, the cycle type, address, beat count and byte enables are all kept unchanged. Sleep handling is the only exception.
- R6: `mem_be` shows the `byte_en` value captured at the most recent edge with `hold`=0, so every beat of a write burst carries its own byte selects.
- R7: `bus_drive` equals `oe` AND (read burst active) AND (not asleep). It follows `oe` combinationally and is 0 for the whole of a write burst, whatever `oe` is.
- R8: While and after reset, until the first load, the device is deselected: `mem_rd`=0, `mem_wr`=0 and `bus_drive`=0, even with `oe`=1.
- R9: `asleep` rises after the second edge at which `sleep_req` is seen high, and falls after the second edge at which it is seen low. While `asleep`=1 both strobes are 0, and a burst in flight at sleep entry is dropped.
- R10: While asleep, and for the `REC_CYCLES` (default 2) edges after `asleep` falls, a load with `chip_sel`=1 and `hold`=0 is treated as a deselect. In that case `access_err` is 1 for the one cycle after the edge; otherwise `access_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | 1 makes the edge a wait cycle |
| chip_sel | input | 1 | Combined chip select, active high |
| advance | input | 1 | 0 loads an address, 1 advances the burst |
| wr | input | 1 | 1 marks a loaded burst as a write |
| byte_en | input | NB | Byte selects for the current beat |
| addr_in | input | AW | External address, used on load |
| burst_order | input | 1 | 0 linear, 1 interleaved (static strap) |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep_req | input | 1 | Asynchronous sleep request |
| mem_addr | output | AW | Address of the current beat |
| mem_rd | output | 1 | Current cycle is a read beat |
| mem_wr | output | 1 | Current cycle is a write beat |
| mem_be | output | NB | Byte enables of the current beat |
| bus_drive | output | 1 | Data bus drive enable |
| asleep | output | 1 | Synchronized sleep state |
| access_err | output | 1 | Access refused during sleep or recovery |

## Verification
The properties assume that `burst_order` is a static strap. The address-step and hold-stability checks are therefore excused in any cycle where it has moved. The bench changes it only rarely, between bursts or mid-burst, so that those excused cycles stay few. The properties also assume that `sleep_req` is steady long enough to be seen by the synchronizer. The random stimulus holds each sleep level for many cycles, toggling it with low probability. Every other input is drawn fresh each cycle, including loads and advances issued while asleep or recovering, so that the refusal path is reached often.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int REC_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          chip_sel,
  input  logic          advance,
  input  logic          wr,
  input  logic [NB-1:0] byte_en,
  input  logic [AW-1:0] addr_in,
  input  logic          burst_order,
  input  logic          oe,
  input  logic          sleep_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [NB-1:0] mem_be,
  output logic          bus_drive,
  output logic          asleep,
  output logic          access_err
);
  localparam int RW = $clog2(REC_CYCLES + 1);

  logic          s1, s2;
  logic [RW-1:0] rec;
  logic          act_q, wr_q, err_q;
  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;
  logic [NB-1:0] be_q;
  logic          blocked;
  logic [1:0]    low;

  assign blocked = s2 | (rec != '0);
  assign low = burst_order ? (base_q[1:0] ^ beat_q) : (base_q[1:0] + beat_q);

  assign mem_addr   = {base_q[AW-1:2], low};
  assign mem_rd     = act_q & ~wr_q & ~s2;
  assign mem_wr     = act_q & wr_q & ~s2;
  assign mem_be     = be_q;
  assign bus_drive  = oe & act_q & ~wr_q & ~s2;
  assign asleep     = s2;
  assign access_err = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      rec <= '0;
    end else begin
      s1 <= sleep_req;
      s2 <= s1;
      if (s2 && !s1)
        rec <= RW'(REC_CYCLES);
      else if (rec != '0)
        rec <= rec - RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      be_q   <= '0;
    end else begin
      err_q <= blocked & ~hold & ~advance & chip_sel;
      if (blocked) begin
        act_q <= 1'b0;
      end else if (!hold) begin
        if (!advance) begin
          act_q <= chip_sel;
          if (chip_sel) begin
            wr_q   <= wr;
            base_q <= addr_in;
            beat_q <= 2'd0;
          end
        end else if (act_q) begin
          beat_q <= beat_q + 2'd1;
        end
      end
      if (!hold)
        be_q <= byte_en;
    end
  end
endmodule

module burst_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold,
  input logic          advance,
  input logic          chip_sel,
  input logic          burst_order,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          bus_drive,
  input logic          asleep,
  input logic          access_err,
  input logic          act,
  input logic          blk
);
  p_no_drive_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !bus_drive);

  p_quiet_in_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !(mem_rd || mem_wr));

  p_refused_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && !hold && !advance && chip_sel) |=> (access_err && !mem_rd && !mem_wr));

  p_linear_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && advance && act && !blk && !burst_order) |=>
      ((mem_addr[1:0] == $past(mem_addr[1:0]) + 2'd1) || !$stable(burst_order)));

  p_upper_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && act && !blk) |=> (mem_addr[AW-1:2] == $past(mem_addr[AW-1:2])));

  p_wait_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(mem_addr) || !$stable(burst_order)));
endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .advance(advance), .chip_sel(chip_sel),
  .burst_order(burst_order), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .bus_drive(bus_drive), .asleep(asleep), .access_err(access_err),
  .act(act_q), .blk(blocked)
);

// File: tb/burst_seq_test.sv
`timescale 1ns/1ps
module burst_seq_test;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int REC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hold = 0, chip_sel = 0, advance = 0, wr = 0, burst_order = 0, oe = 1, sleep_req = 0;
  logic [NB-1:0] byte_en = '0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, bus_drive, asleep, access_err;
  logic [NB-1:0] mem_be;

  int n_chk = 0, n_fail = 0;

  logic m_act = 0, m_w = 0, m_err = 0, m_s1 = 0, m_s2 = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_cnt = '0;
  logic [NB-1:0] m_be = '0;
  int m_rec = 0;

  always #2 clk = ~clk;

  burst_seq #(.AW(AW), .NB(NB), .REC_CYCLES(REC)) uut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .chip_sel(chip_sel), .advance(advance),
    .wr(wr), .byte_en(byte_en), .addr_in(addr_in), .burst_order(burst_order), .oe(oe),
    .sleep_req(sleep_req), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_be(mem_be), .bus_drive(bus_drive), .asleep(asleep), .access_err(access_err)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = burst_order ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic model_step();
    logic blk;
    blk = m_s2 | (m_rec != 0);
    m_err = blk & ~hold & ~advance & chip_sel;
    if (blk) m_act = 1'b0;
    else if (!hold) begin
      if (!advance) begin
        m_act = chip_sel;
        if (chip_sel) begin m_w = wr; m_base = addr_in; m_cnt = 2'd0; end
      end else if (m_act) m_cnt = m_cnt + 2'd1;
    end
    if (!hold) m_be = byte_en;
    if (m_s2 && !m_s1) m_rec = REC;
    else if (m_rec != 0) m_rec--;
    m_s2 = m_s1;
    m_s1 = sleep_req;
  endtask

  task automatic check_all();
    chk("R3 address", mem_addr, exp_addr());
    chk("R1 read strobe", mem_rd, m_act & ~m_w & ~m_s2);
    chk("R1 write strobe", mem_wr, m_act & m_w & ~m_s2);
    chk("R6 byte enables", mem_be, m_be);
    chk("R7 drive", bus_drive, oe & m_act & ~m_w & ~m_s2);
    chk("R9 asleep", asleep, m_s2);
    chk("R10 error", access_err, m_err);
  endtask

  task automatic cyc(input logic sel, input logic adv, input logic w, input logic hld,
                     input logic [NB-1:0] be, input logic [AW-1:0] a, input logic o,
                     input logic slp);
    chip_sel = sel; advance = adv; wr = w; hold = hld;
    byte_en = be; addr_in = a; oe = o; sleep_req = slp;
    #1;
    chk("R7 async oe", bus_drive, o & m_act & ~m_w & ~m_s2);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (R1..R10 incomplete): got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7215));
    repeat (3) @(negedge clk);
    chk("R8 reset drive", bus_drive, 1'b0);
    chk("R8 reset read", mem_rd, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", {mem_rd, mem_wr, bus_drive}, 3'b000);

    burst_order = 1'b0;
    cyc(1, 0, 0, 0, 4'hF, 8'h45, 1, 0);
    chk("R1 load read", {mem_rd, mem_wr}, 2'b10);
    chk("R1 load addr", mem_addr, 8'h45);
    cyc(0, 1, 1, 0, 4'hF, 8'hFF, 1, 0);
    chk("R2 ignores sel/wr", {mem_rd, mem_wr}, 2'b10);
    chk("R3 linear beat2", mem_addr, 8'h46);
    cyc(1, 1, 1, 0, 4'hF, 8'h00, 1, 0);
    chk("R3 linear beat3", mem_addr, 8'h47);
    cyc(1, 1, 0, 1, 4'h3, 8'h00, 1, 0);
    chk("R5 wait addr", mem_addr, 8'h47);
    chk("R5 wait be", mem_be, 4'hF);
    cyc(1, 1, 0, 0, 4'hF, 8'h00, 1, 0);
    chk("R3 linear beat4", mem_addr, 8'h44);
    cyc(1, 1, 0, 0, 4'hF, 8'h00, 1, 0);
    chk("R3 wrap to start", mem_addr, 8'h45);

    burst_order = 1'b1;
    cyc(1, 0, 1, 0, 4'h5, 8'h2A, 1, 0);
    chk("R1 load write", {mem_rd, mem_wr}, 2'b01);
    chk("R7 no drive in write", bus_drive, 1'b0);
    cyc(0, 1, 0, 0, 4'hA, 8'h00, 1, 0);
    chk("R3 interleaved beat2", mem_addr, 8'h2B);
    chk("R6 per-beat be", mem_be, 4'hA);
    cyc(0, 1, 0, 0, 4'h1, 8'h00, 1, 0);
    chk("R3 interleaved beat3", mem_addr, 8'h28);
    cyc(0, 1, 0, 0, 4'h8, 8'h00, 1, 0);
    chk("R3 interleaved beat4", mem_addr, 8'h29);

    cyc(0, 0, 0, 0, 4'h0, 8'h10, 1, 0);
    chk("R4 deselect", {mem_rd, mem_wr}, 2'b00);
    cyc(1, 1, 0, 0, 4'h0, 8'h10, 1, 0);
    chk("R4 stays deselected", {mem_rd, mem_wr, bus_drive}, 3'b000);

    cyc(1, 0, 0, 0, 4'hF, 8'h80, 1, 1);
    chk("R9 one edge not asleep", asleep, 1'b0);
    cyc(1, 1, 0, 0, 4'hF, 8'h80, 1, 1);
    chk("R9 asleep after two edges", asleep, 1'b1);
    chk("R9 strobes off", {mem_rd, bus_drive}, 2'b00);
    cyc(1, 0, 0, 0, 4'hF, 8'h90, 1, 1);
    chk("R10 refused in sleep", {access_err, mem_rd}, 2'b10);
    cyc(0, 0, 0, 0, 4'hF, 8'h90, 1, 0);
    chk("R9 exit needs two edges", asleep, 1'b1);
    cyc(0, 0, 0, 0, 4'hF, 8'h90, 1, 0);
    chk("R9 awake", asleep, 1'b0);
    cyc(1, 0, 0, 0, 4'hF, 8'h90, 1, 0);
    chk("R10 refused recovery 1", {access_err, mem_rd}, 2'b10);
    cyc(1, 0, 0, 0, 4'hF, 8'h90, 1, 0);
    chk("R10 refused recovery 2", {access_err, mem_rd}, 2'b10);
    cyc(1, 0, 0, 0, 4'hF, 8'h90, 1, 0);
    chk("R10 accepted after recovery", {access_err, mem_rd}, 2'b01);

    begin
      logic slp = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom % 64 == 0) slp = ~slp;
        if ($urandom % 150 == 0) burst_order = ~burst_order;
        cyc(($urandom % 5) != 0, ($urandom % 5) < 3, $urandom % 2, ($urandom % 5) == 0,
            NB'($urandom), AW'($urandom), $urandom % 2, slp);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule